// File: doc/BRIEF.md
# Two-Thread Register Rename Stage

This block renames register operands for a core that interleaves two hardware threads. Each thread sees its own set of architectural register names. Every name is translated through a private speculative map table. All physical registers come from one pool shared by both threads, so the live values of the two threads always occupy different physical registers.

At most one instruction arrives per cycle, tagged with its thread. The block answers in the same cycle with the following:
- the physical tags of both source operands;
- a freshly allocated physical tag for the destination, if there is one;
- the tag the destination name held before, which the pipeline later releases at commit.

A commit port moves a thread's committed view forward and frees the superseded tag. A per-thread flush input rolls that thread's speculative map back to its committed view. The flush also reclaims every register that thread allocated but never committed.

Top module: `rename_2t`

## Requirements
- R1: After reset, thread 0 maps architectural register a to physical tag a, and thread 1 maps it to tag 8+a. Tags 16 to 143 start out free.
- R2: Lookups use only the table of the thread named by `ren_tid` (0 or 1). A destination rename in one thread leaves every lookup of the other thread unchanged.
- R3: Every accepted instruction with a destination receives a physical tag that is currently free. No check is made on whether renaming is needed. The tag is the lowest-numbered free one, so successive allocations after reset yield 16, 17, 18 and so on.
- R4: `ren_old_tag` reports the mapping the destination name held before the rename. Later lookups of that name in the same thread return the new tag, while the old tag stays out of the free pool until committed.
- R5: Source tags are read before the same instruction's destination update. A source naming the destination register therefore receives the older mapping.
- R6: When no physical register is free, an instruction with a destination raises `ren_stall`, keeps `ren_ok` low and changes no state. An instruction without a destination is still accepted.
- R7: A commit (`cmt_valid`) records `cmt_new_tag` as the committed mapping of `cmt_areg` for `cmt_tid`. It also returns `cmt_old_tag` to the pool, where it can be allocated from the next cycle on.
- R8: A flush of thread t (bit t of `flush`) replaces t's speculative map with its committed map. It frees every tag that t allocated and has not committed, and leaves the other thread's map and allocations untouched.
- R9: An instruction arriving for a thread whose flush bit is high in the same cycle is dropped: `ren_ok` is low and no register is allocated.
- R10: No physical tag is mapped by both threads' speculative tables at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | An instruction is presented this cycle |
| ren_tid | input | 1 | Thread of the presented instruction |
| ren_src0 | input | 3 | First source architectural register |
| ren_src1 | input | 3 | Second source architectural register |
| ren_dst_valid | input | 1 | Instruction writes a destination |
| ren_dst | input | 3 | Destination architectural register |
| ren_ok | output | 1 | Instruction accepted this cycle |
| ren_stall | output | 1 | Destination needed but pool empty |
| ren_src0_tag | output | 8 | Physical tag of first source |
| ren_src1_tag | output | 8 | Physical tag of second source |
| ren_new_tag | output | 8 | Tag allocated to the destination |
| ren_old_tag | output | 8 | Previous tag of the destination name |
| cmt_valid | input | 1 | A destination commits this cycle |
| cmt_tid | input | 1 | Thread of the committing instruction |
| cmt_areg | input | 3 | Architectural destination being committed |
| cmt_new_tag | input | 8 | Tag that becomes committed state |
| cmt_old_tag | input | 8 | Superseded tag to be freed |
| flush | input | 2 | Per-thread flush, bit t for thread t |

## Verification
The hardest condition to reach is an exhausted pool. Getting there takes 128 accepted destination renames with no commits in between, and R6 and the refill order of R7 only show up once that state is reached. The stimulus alternates threads through that whole fill and checks every allocated tag against the expected ascending sequence. It then probes the stall, commits a single old mapping to reopen one slot, and flushes one thread. That flush returns a large, scattered set of tags, and the rollback is exercised while the other thread still holds half the pool.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int unsigned RN_ARCH_DEF  = 8;
  parameter int unsigned RN_PHYS_DEF  = 144;
  parameter int unsigned RN_TAG_W_DEF = 8;
  localparam int unsigned RN_THREADS  = 2;
  typedef logic tid_t;
endpackage

// File: rtl/rn_rst_sync.sv
module rn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_ln = s2_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_N = 8,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned BASE   = 0,
  localparam int unsigned AW    = $clog2(ARCH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd0_a,
  input  logic [AW-1:0]    rd1_a,
  input  logic [AW-1:0]    rdd_a,
  output logic [TAG_W-1:0] rd0_t,
  output logic [TAG_W-1:0] rd1_t,
  output logic [TAG_W-1:0] rdd_t,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_a,
  input  logic [TAG_W-1:0] wr_t,
  input  logic             cm_en,
  input  logic [AW-1:0]    cm_a,
  input  logic [TAG_W-1:0] cm_t,
  input  logic             flush
);
  logic [TAG_W-1:0] spec_q [ARCH_N];
  logic [TAG_W-1:0] spec_d [ARCH_N];
  logic [TAG_W-1:0] arch_q [ARCH_N];
  logic [TAG_W-1:0] arch_d [ARCH_N];

  assign rd0_t = spec_q[rd0_a];
  assign rd1_t = spec_q[rd1_a];
  assign rdd_t = spec_q[rdd_a];

  always_comb begin
    arch_d = arch_q;
    if (cm_en) arch_d[cm_a] = cm_t;
    spec_d = spec_q;
    if (flush) spec_d = arch_d;
    else if (wr_en) spec_d[wr_a] = wr_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ARCH_N); i++) begin
        spec_q[i] <= TAG_W'(BASE + i);
        arch_q[i] <= TAG_W'(BASE + i);
      end
    end else begin
      spec_q <= spec_d;
      arch_q <= arch_d;
    end
  end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int unsigned PHYS_N = 144,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned RSV_N  = 16,
  parameter int unsigned NTHR   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             alloc_tid,
  input  logic             rel_en,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic             cm_en,
  input  logic             cm_tid,
  input  logic [TAG_W-1:0] cm_tag,
  input  logic [NTHR-1:0]  flush,
  output logic             avail,
  output logic [TAG_W-1:0] pick
);
  logic [PHYS_N-1:0]            free_q, free_d;
  logic [NTHR-1:0][PHYS_N-1:0]  pend_q, pend_d;

  assign avail = |free_q;

  always_comb begin
    pick = '0;
    for (int i = int'(PHYS_N) - 1; i >= 0; i--) begin
      if (free_q[i]) pick = TAG_W'(i);
    end
  end

  always_comb begin
    free_d = free_q;
    pend_d = pend_q;
    if (cm_en)  pend_d[cm_tid][cm_tag] = 1'b0;
    if (rel_en) free_d[rel_tag]        = 1'b1;
    for (int t = 0; t < int'(NTHR); t++) begin
      if (flush[t]) begin
        free_d    = free_d | pend_d[t];
        pend_d[t] = '0;
      end
    end
    if (alloc_en) begin
      free_d[pick]            = 1'b0;
      pend_d[alloc_tid][pick] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(PHYS_N); i++) free_q[i] <= (i >= int'(RSV_N));
      pend_q <= '0;
    end else begin
      free_q <= free_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/rename_2t.sv
module rename_2t #(
  parameter int unsigned ARCH_N  = rn_pkg::RN_ARCH_DEF,
  parameter int unsigned PHYS_N  = rn_pkg::RN_PHYS_DEF,
  parameter int unsigned TAG_W   = rn_pkg::RN_TAG_W_DEF,
  localparam int unsigned AW     = $clog2(ARCH_N),
  localparam int unsigned NTHR   = rn_pkg::RN_THREADS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  input  logic             ren_tid,
  input  logic [AW-1:0]    ren_src0,
  input  logic [AW-1:0]    ren_src1,
  input  logic             ren_dst_valid,
  input  logic [AW-1:0]    ren_dst,
  output logic             ren_ok,
  output logic             ren_stall,
  output logic [TAG_W-1:0] ren_src0_tag,
  output logic [TAG_W-1:0] ren_src1_tag,
  output logic [TAG_W-1:0] ren_new_tag,
  output logic [TAG_W-1:0] ren_old_tag,
  input  logic             cmt_valid,
  input  logic             cmt_tid,
  input  logic [AW-1:0]    cmt_areg,
  input  logic [TAG_W-1:0] cmt_new_tag,
  input  logic [TAG_W-1:0] cmt_old_tag,
  input  logic [NTHR-1:0]  flush
);
  import rn_pkg::*;

  logic             rst_ln;
  logic             pool_avail;
  logic [TAG_W-1:0] pool_pick;
  logic             killed;
  logic             alloc_en;
  logic [TAG_W-1:0] s0_t [NTHR];
  logic [TAG_W-1:0] s1_t [NTHR];
  logic [TAG_W-1:0] dd_t [NTHR];

  rn_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_ln)
  );

  assign killed    = flush[ren_tid];
  assign ren_stall = ren_valid && ren_dst_valid && !pool_avail;
  assign ren_ok    = ren_valid && !killed && !ren_stall;
  assign alloc_en  = ren_ok && ren_dst_valid;

  generate
    for (genvar t = 0; t < int'(NTHR); t++) begin : g_thr
      rn_map_table #(
        .ARCH_N (ARCH_N),
        .TAG_W  (TAG_W),
        .BASE   (t * ARCH_N)
      ) u_map (
        .clk   (clk),
        .rst_n (rst_ln),
        .rd0_a (ren_src0),
        .rd1_a (ren_src1),
        .rdd_a (ren_dst),
        .rd0_t (s0_t[t]),
        .rd1_t (s1_t[t]),
        .rdd_t (dd_t[t]),
        .wr_en (alloc_en && (ren_tid == tid_t'(t))),
        .wr_a  (ren_dst),
        .wr_t  (pool_pick),
        .cm_en (cmt_valid && (cmt_tid == tid_t'(t))),
        .cm_a  (cmt_areg),
        .cm_t  (cmt_new_tag),
        .flush (flush[t])
      );
    end
  endgenerate

  rn_free_pool #(
    .PHYS_N (PHYS_N),
    .TAG_W  (TAG_W),
    .RSV_N  (NTHR * ARCH_N),
    .NTHR   (NTHR)
  ) u_pool (
    .clk       (clk),
    .rst_n     (rst_ln),
    .alloc_en  (alloc_en),
    .alloc_tid (ren_tid),
    .rel_en    (cmt_valid),
    .rel_tag   (cmt_old_tag),
    .cm_en     (cmt_valid),
    .cm_tid    (cmt_tid),
    .cm_tag    (cmt_new_tag),
    .flush     (flush),
    .avail     (pool_avail),
    .pick      (pool_pick)
  );

  assign ren_src0_tag = s0_t[ren_tid];
  assign ren_src1_tag = s1_t[ren_tid];
  assign ren_old_tag  = dd_t[ren_tid];
  assign ren_new_tag  = pool_pick;
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned AW     = 3,
  parameter int unsigned PHYS_N = 144
) (
  input logic             clk,
  input logic             rst_ln,
  input logic             ren_valid,
  input logic             ren_tid,
  input logic [AW-1:0]    ren_src0,
  input logic             ren_dst_valid,
  input logic [AW-1:0]    ren_dst,
  input logic             ren_ok,
  input logic             ren_stall,
  input logic [TAG_W-1:0] ren_src0_tag,
  input logic [TAG_W-1:0] ren_src1_tag,
  input logic [TAG_W-1:0] ren_new_tag,
  input logic [TAG_W-1:0] ren_old_tag,
  input logic [1:0]       flush
);
  // R6: a stalled instruction is never accepted
  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_ln)
    ren_stall |-> !ren_ok);

  // R9: a same-cycle flush of the instruction's thread drops it
  a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_ln)
    (ren_valid && flush[ren_tid]) |-> !ren_ok);

  // R3: the allocated tag is in range and differs from every mapped tag
  a_r3_fresh_tag: assert property (@(posedge clk) disable iff (!rst_ln)
    (ren_ok && ren_dst_valid) |->
      (ren_new_tag < TAG_W'(PHYS_N)) && (ren_new_tag != ren_old_tag) &&
      (ren_new_tag != ren_src0_tag) && (ren_new_tag != ren_src1_tag));

  // R3: back-to-back allocations never hand out the same tag
  a_r3_no_reuse: assert property (@(posedge clk) disable iff (!rst_ln)
    (ren_ok && ren_dst_valid) |=>
      (!(ren_ok && ren_dst_valid) || (ren_new_tag != $past(ren_new_tag))));

  // R4: a following lookup of the renamed name in the same thread sees the new tag
  a_r4_new_mapping: assert property (@(posedge clk) disable iff (!rst_ln)
    (ren_ok && ren_dst_valid) |=>
      (!(ren_valid && (ren_tid == $past(ren_tid)) && (ren_src0 == $past(ren_dst))) ||
       (ren_src0_tag == $past(ren_new_tag))));
endmodule

bind rename_2t rn_checker #(
  .TAG_W  (TAG_W),
  .AW     (AW),
  .PHYS_N (PHYS_N)
) u_chk (.*);

// File: tb/sim_rename_2t.sv
`timescale 1ns/1ps
module sim_rename_2t;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_tid, ren_dst_valid;
  logic [2:0] ren_src0, ren_src1, ren_dst;
  logic       ren_ok, ren_stall;
  logic [7:0] ren_src0_tag, ren_src1_tag, ren_new_tag, ren_old_tag;
  logic       cmt_valid, cmt_tid;
  logic [2:0] cmt_areg;
  logic [7:0] cmt_new_tag, cmt_old_tag;
  logic [1:0] flush;

  always #10 clk = ~clk;

  rename_2t u0 (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_tid(ren_tid), .ren_src0(ren_src0), .ren_src1(ren_src1),
    .ren_dst_valid(ren_dst_valid), .ren_dst(ren_dst),
    .ren_ok(ren_ok), .ren_stall(ren_stall), .ren_src0_tag(ren_src0_tag),
    .ren_src1_tag(ren_src1_tag), .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_areg(cmt_areg),
    .cmt_new_tag(cmt_new_tag), .cmt_old_tag(cmt_old_tag), .flush(flush)
  );

  int m_spec [2][8];
  int m_cmt  [2][8];
  bit m_free [144];
  bit m_pend [2][144];
  int r_t [256], r_a [256], r_n [256], r_o [256];
  bit r_v [256];
  int r_cnt;
  int n_chk, n_fail;
  int g_s0, g_new;

  task automatic chk(bit good, string req, int act, int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int p = 0; p < 144; p++) if (m_free[p]) return p;
    return -1;
  endfunction

  task automatic step(bit rv, int t, int s0, int s1, bit dv, int d,
                      bit cv, int ct, int ca, int cn, int co, bit [1:0] fl, string req);
    int  n;
    bit  e_stall, e_ok;
    @(negedge clk);
    ren_valid = rv; ren_tid = t[0]; ren_src0 = s0[2:0]; ren_src1 = s1[2:0];
    ren_dst_valid = dv; ren_dst = d[2:0];
    cmt_valid = cv; cmt_tid = ct[0]; cmt_areg = ca[2:0];
    cmt_new_tag = cn[7:0]; cmt_old_tag = co[7:0]; flush = fl;
    #2;
    n = lowest_free();
    e_stall = rv && dv && (n < 0);
    e_ok    = rv && !fl[t] && !e_stall;
    chk(ren_stall == e_stall, "R6 stall", int'(ren_stall), int'(e_stall));
    chk(ren_ok == e_ok, (fl[t] && rv) ? "R9 accept" : "R6 accept", int'(ren_ok), int'(e_ok));
    g_s0  = int'(ren_src0_tag);
    g_new = int'(ren_new_tag);
    if (rv) begin
      chk(int'(ren_src0_tag) == m_spec[t][s0], req, int'(ren_src0_tag), m_spec[t][s0]);
      chk(int'(ren_src1_tag) == m_spec[t][s1], req, int'(ren_src1_tag), m_spec[t][s1]);
    end
    if (e_ok && dv) begin
      chk(int'(ren_new_tag) == n, "R3 new tag", int'(ren_new_tag), n);
      chk(int'(ren_old_tag) == m_spec[t][d], "R4 old tag", int'(ren_old_tag), m_spec[t][d]);
    end
    if (cv) begin
      m_cmt[ct][ca] = cn; m_pend[ct][cn] = 1'b0; m_free[co] = 1'b1;
    end
    for (int th = 0; th < 2; th++) begin
      if (fl[th]) begin
        for (int a = 0; a < 8; a++) m_spec[th][a] = m_cmt[th][a];
        for (int p = 0; p < 144; p++) if (m_pend[th][p]) begin
          m_free[p] = 1'b1; m_pend[th][p] = 1'b0;
        end
        for (int k = 0; k < r_cnt; k++) if (r_t[k] == th) r_v[k] = 1'b0;
      end
    end
    if (e_ok && dv) begin
      m_free[n] = 1'b0; m_pend[t][n] = 1'b1;
      r_t[r_cnt] = t; r_a[r_cnt] = d; r_n[r_cnt] = n; r_o[r_cnt] = m_spec[t][d];
      r_v[r_cnt] = 1'b1; r_cnt++;
      m_spec[t][d] = n;
    end
  endtask

  task automatic ren(int t, int s0, int s1, bit dv, int d, string req);
    step(1'b1, t, s0, s1, dv, d, 1'b0, 0, 0, 0, 0, 2'b00, req);
  endtask

  task automatic commit_oldest(int t);
    for (int k = 0; k < r_cnt; k++) begin
      if (r_v[k] && r_t[k] == t) begin
        r_v[k] = 1'b0;
        step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1, t, r_a[k], r_n[k], r_o[k], 2'b00, "R7");
        return;
      end
    end
  endtask

  task automatic sweep(string req, bit arith);
    bit seen [2][256];
    int ov;
    ov = 0;
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 256; p++) seen[t][p] = 1'b0;
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < 8; a++) begin
        ren(t, a, (a + 3) % 8, 1'b0, 0, req);
        seen[t][g_s0] = 1'b1;
        if (arith) chk(g_s0 == t * 8 + a, "R1 reset map", g_s0, t * 8 + a);
      end
    end
    for (int p = 0; p < 256; p++) if (seen[0][p] && seen[1][p]) ov++;
    chk(ov == 0, "R10 disjoint", ov, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; r_cnt = 0;
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 8; a++) begin
        m_spec[t][a] = t * 8 + a; m_cmt[t][a] = t * 8 + a;
      end
    for (int p = 0; p < 144; p++) begin
      m_free[p] = (p >= 16); m_pend[0][p] = 1'b0; m_pend[1][p] = 1'b0;
    end
    rst_n = 1'b0;
    ren_valid = 0; ren_tid = 0; ren_src0 = 0; ren_src1 = 0; ren_dst_valid = 0; ren_dst = 0;
    cmt_valid = 0; cmt_tid = 0; cmt_areg = 0; cmt_new_tag = 0; cmt_old_tag = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset mapping of both threads, R10 disjoint
    sweep("R1", 1'b1);

    // R5 source equal to destination reads the older tag; R4, R2 afterwards
    ren(0, 3, 5, 1'b1, 3, "R5 src before dst");
    chk(g_s0 == 3, "R5 old mapping", g_s0, 3);
    chk(g_new == 16, "R3 first alloc", g_new, 16);
    ren(1, 3, 3, 1'b0, 0, "R2 other thread");
    chk(g_s0 == 11, "R2 other thread", g_s0, 11);
    ren(0, 3, 3, 1'b0, 0, "R4 new mapping");
    chk(g_s0 == 16, "R4 new mapping", g_s0, 16);

    // R3 fill the pool, alternating threads, ascending tags
    for (int i = 0; i < 127; i++) begin
      ren(i % 2, (i / 2) % 8, ((i / 2) + 1) % 8, 1'b1, (i / 2) % 8, "R3 fill");
      chk(g_new == 17 + i, "R3 ascending", g_new, 17 + i);
    end
    // R6 empty pool: dest instruction stalls, no-dest instruction accepted
    ren(1, 0, 1, 1'b1, 5, "R6 stall");
    ren(0, 2, 4, 1'b0, 0, "R6 no dest");
    sweep("R10", 1'b0);

    // R7 commit frees the old tag, reusable next cycle
    commit_oldest(0);
    ren(1, 2, 2, 1'b1, 2, "R7 reuse");
    chk(g_new == 3, "R7 reuse", g_new, 3);
    ren(0, 1, 1, 1'b1, 1, "R6 stall again");

    // R8 commit some of thread 1 then flush thread 0
    commit_oldest(1);
    commit_oldest(1);
    commit_oldest(1);
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, 2'b01, "R8 flush");
    sweep("R8 after flush", 1'b0);
    ren(0, 3, 3, 1'b0, 0, "R8 committed kept");
    chk(g_s0 == 16, "R8 committed kept", g_s0, 16);
    ren(0, 0, 6, 1'b1, 0, "R8 realloc");

    // R9 rename in the same cycle as its thread's flush is dropped
    step(1'b1, 1, 4, 4, 1'b1, 4, 1'b0, 0, 0, 0, 0, 2'b10, "R9 flush drop");
    ren(1, 4, 2, 1'b1, 4, "R9 after flush");
    // flush both threads together, then full lookup sweep
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, 2'b11, "R8 flush both");
    sweep("R10", 1'b0);
    for (int i = 0; i < 10; i++) ren(i % 2, i % 8, (i + 5) % 8, 1'b1, (i * 3) % 8, "R3 refill");
    sweep("R10", 1'b0);

    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, 2'b00, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule